// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Calculator

This block turns a requested local-oscillator frequency, given as a whole number of MHz, into the programming values for an integer-mode frequency synthesizer. It picks a power-of-two output divider so that the VCO runs near the top of its range. It then chooses the feedback prescaler and charge-pump code from the VCO frequency, and forms a fixed-point feedback ratio with 29 fraction bits against a 50 MHz reference. That ratio is split into an integer divider field and two fraction fields. The block also reports the frequency the synthesizer will actually produce, in Hz.

A caller presents a frequency and pulses `start` while the block is idle. One shared restoring divider, which yields one quotient bit per clock, first forms the range ratio 5400 / LO and then the wide feedback quotient. All result fields are registered. They change only in the single cycle in which `done` is high, and they hold until the next successful calculation. A request of 0 MHz is refused at once: `err` is raised and the fields are left untouched.

Top module: `intn_divcalc`

## Requirements
- R1: After reset, busy, done and err are 0 and every result field reads 0.
- R2: The exponent div_exp starts at 0 with x = 5400 / lo (integer division). While x > 1 and div_exp < 5, div_exp is incremented and x is halved, so div_exp never exceeds 5.
- R3: vco_mhz equals lo_mhz multiplied by 2^div_exp.
- R4: If vco_mhz > 3200, the feedback divider is 4, fb_presc is 2 and cp_code is 3. Otherwise the feedback divider is 2, fb_presc is 1 and cp_code is 2. A VCO of exactly 3200 takes the lower setting.
- R5: With q = (vco_mhz * 2^29) / (feedback divider * 50), computed exactly: n_int = q >> 29, frac_hi = q bits 28..13 and frac_lo = q bits 12..5. All fields change only in the cycle in which done is high.
- R6: tune_hz = (50 * (q >> 5) * feedback divider * 1000000) / (2^div_exp * 2^24), with the result truncated.
- R7: For a non-zero lo_mhz, done is high for exactly one cycle, 94 rising edges after the edge that samples start. busy is high from the cycle after that edge until done rises, and busy is low while done is high.
- R8: A start with lo_mhz = 0 raises err and done in the very next cycle, leaves busy low, and leaves every result field unchanged.
- R9: A start that arrives while busy is high is ignored. The calculation in progress completes with its own input.
- R10: A start presented in the cycle in which done is high is accepted and begins a new calculation.
- R11: err returns to 0 when a later start with a non-zero lo_mhz is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, honoured only while idle |
| lo_mhz | input | 16 | Requested LO frequency in MHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when a result or rejection is ready |
| err | output | 1 | Last request was 0 MHz |
| div_exp | output | 3 | Output divider exponent (divider = 2^div_exp) |
| vco_mhz | output | 16 | VCO frequency in MHz |
| fb_presc | output | 2 | Feedback divider shifted right by one |
| cp_code | output | 2 | Charge-pump code |
| n_int | output | 16 | Integer part of the feedback ratio |
| frac_hi | output | 16 | Upper fraction field, q bits 28..13 |
| frac_lo | output | 8 | Lower fraction field, q bits 12..5 |
| tune_hz | output | 40 | Achieved output frequency in Hz |

## Verification
The result pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` with a fresh frequency at once, in the very cycle in which it sees `done`. A reference model checks, on every clock, that the second calculation starts at that edge, that the first result stays on the fields until the second `done`, and that both sets of fields match their own inputs. A second overlap, a `start` that arrives in mid-calculation, is provoked with a different frequency. It is judged by the model's cycle-by-cycle agreement on `busy`, `done` and the unchanged final fields.

// File: rtl/intn_divcalc_pkg.sv
`timescale 1ns/1ps
package intn_divcalc_pkg;

  localparam int LO_W       = 16;
  localparam int FRAC_BITS  = 29;
  localparam int DIV_W      = LO_W + FRAC_BITS;
  localparam int DROP       = 5;
  localparam int LSB_SCALE  = FRAC_BITS - DROP;
  localparam int HI_W       = 16;
  localparam int LO_FW      = 8;
  localparam int MAX_LO     = 5400;
  localparam int REF_MHZ    = 50;
  localparam int VCO_SPLIT  = 3200;
  localparam int EXP_CAP    = 5;
  localparam int EXP_W      = $clog2(EXP_CAP + 1);
  localparam int TUNE_W     = 40;
  localparam int HZ_PER_MHZ = 1000000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RATIO,
    S_LAUNCH,
    S_QUOT,
    S_FIN
  } calc_state_t;

  // Halve the range ratio until it reaches 1 or the exponent reaches its cap.
  function automatic logic [EXP_W-1:0] f_exp(input logic [DIV_W-1:0] ratio);
    logic [DIV_W-1:0] x;
    logic [EXP_W-1:0] e;
    x = ratio;
    e = '0;
    for (int i = 0; i < EXP_CAP; i++) begin
      if (x > DIV_W'(1)) begin
        e = e + EXP_W'(1);
        x = x >> 1;
      end
    end
    return e;
  endfunction

  // Achieved frequency: the divide by 2^(24+e) is an exact right shift.
  function automatic logic [TUNE_W-1:0] f_tune(input logic [DIV_W-1:0] q,
                                               input logic [EXP_W-1:0] e,
                                               input logic fb_hi);
    logic [63:0] scale;
    logic [63:0] num;
    scale = fb_hi ? 64'(REF_MHZ * 4 * HZ_PER_MHZ) : 64'(REF_MHZ * 2 * HZ_PER_MHZ);
    num   = 64'(q >> DROP) * scale;
    num   = num >> (LSB_SCALE + int'(e));
    return num[TUNE_W-1:0];
  endfunction

endpackage

// File: rtl/intn_seqdiv.sv
`timescale 1ns/1ps
module intn_seqdiv #(
  parameter int DW = 45,
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          valid,
  output logic [DW-1:0] quot
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] qsh;
  logic [VW-1:0] rem;
  logic [VW-1:0] dvs;
  logic [CW-1:0] cnt;
  logic          run;

  logic [VW:0]   trial;
  logic          fits;
  logic [VW:0]   next_rem;

  assign trial    = {rem, qsh[DW-1]};
  assign fits     = trial >= {1'b0, dvs};
  assign next_rem = fits ? (trial - {1'b0, dvs}) : trial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qsh   <= '0;
      rem   <= '0;
      dvs   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        qsh <= dividend;
        rem <= '0;
        dvs <= divisor;
        cnt <= CW'(DW);
        run <= 1'b1;
      end else if (run) begin
        qsh <= {qsh[DW-2:0], fits};
        rem <= next_rem[VW-1:0];
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quot = qsh;
endmodule

// File: rtl/intn_plan_stage.sv
`timescale 1ns/1ps
module intn_plan_stage
  import intn_divcalc_pkg::*;
(
  input  logic [DIV_W-1:0] ratio,
  input  logic [LO_W-1:0]  lo,
  output logic [EXP_W-1:0] exp_o,
  output logic [LO_W-1:0]  vco_o,
  output logic             fb_hi_o
);
  assign exp_o   = f_exp(ratio);
  assign vco_o   = lo << exp_o;
  assign fb_hi_o = vco_o > LO_W'(VCO_SPLIT);
endmodule

// File: rtl/intn_field_pack.sv
`timescale 1ns/1ps
module intn_field_pack
  import intn_divcalc_pkg::*;
(
  input  logic [DIV_W-1:0]  q,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              fb_hi,
  output logic [LO_W-1:0]   n_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [LO_FW-1:0]  lo_o,
  output logic [1:0]        presc_o,
  output logic [1:0]        pump_o,
  output logic [TUNE_W-1:0] tune_o
);
  assign n_o     = q[DIV_W-1:FRAC_BITS];
  assign hi_o    = q[FRAC_BITS-1 -: HI_W];
  assign lo_o    = q[FRAC_BITS-1-HI_W -: LO_FW];
  assign presc_o = fb_hi ? 2'd2 : 2'd1;
  assign pump_o  = fb_hi ? 2'd3 : 2'd2;
  assign tune_o  = f_tune(q, exp_i, fb_hi);
endmodule

// File: rtl/intn_divcalc.sv
`timescale 1ns/1ps
module intn_divcalc
  import intn_divcalc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LO_W-1:0]   lo_mhz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [EXP_W-1:0]  div_exp,
  output logic [LO_W-1:0]   vco_mhz,
  output logic [1:0]        fb_presc,
  output logic [1:0]        cp_code,
  output logic [LO_W-1:0]   n_int,
  output logic [HI_W-1:0]   frac_hi,
  output logic [LO_FW-1:0]  frac_lo,
  output logic [TUNE_W-1:0] tune_hz
);
  calc_state_t state;

  logic [LO_W-1:0]  lo_q;
  logic [EXP_W-1:0] exp_q;
  logic [LO_W-1:0]  vco_q;
  logic             fbhi_q;
  logic [DIV_W-1:0] q_q;

  logic             accept;
  logic             reject;
  logic             div_go;
  logic             div_valid;
  logic [DIV_W-1:0] div_num;
  logic [LO_W-1:0]  div_den;
  logic [DIV_W-1:0] div_quot;

  logic [EXP_W-1:0] p_exp;
  logic [LO_W-1:0]  p_vco;
  logic             p_fbhi;

  logic [LO_W-1:0]   f_n;
  logic [HI_W-1:0]   f_hi;
  logic [LO_FW-1:0]  f_lo;
  logic [1:0]        f_presc;
  logic [1:0]        f_pump;
  logic [TUNE_W-1:0] f_tn;

  assign accept = (state == S_IDLE) && start && (lo_mhz != '0);
  assign reject = (state == S_IDLE) && start && (lo_mhz == '0);
  assign div_go = accept || (state == S_LAUNCH);

  // The idle state feeds the range ratio; later states feed the feedback quotient.
  assign div_num = (state == S_IDLE) ? DIV_W'(MAX_LO) : {vco_q, {FRAC_BITS{1'b0}}};
  assign div_den = (state == S_IDLE) ? lo_mhz
                 : (fbhi_q ? LO_W'(REF_MHZ * 4) : LO_W'(REF_MHZ * 2));

  intn_seqdiv #(.DW(DIV_W), .VW(LO_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_num),
    .divisor  (div_den),
    .valid    (div_valid),
    .quot     (div_quot)
  );

  intn_plan_stage u_plan (
    .ratio   (div_quot),
    .lo      (lo_q),
    .exp_o   (p_exp),
    .vco_o   (p_vco),
    .fb_hi_o (p_fbhi)
  );

  intn_field_pack u_pack (
    .q       (q_q),
    .exp_i   (exp_q),
    .fb_hi   (fbhi_q),
    .n_o     (f_n),
    .hi_o    (f_hi),
    .lo_o    (f_lo),
    .presc_o (f_presc),
    .pump_o  (f_pump),
    .tune_o  (f_tn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lo_q     <= '0;
      exp_q    <= '0;
      vco_q    <= '0;
      fbhi_q   <= 1'b0;
      q_q      <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      div_exp  <= '0;
      vco_mhz  <= '0;
      fb_presc <= '0;
      cp_code  <= '0;
      n_int    <= '0;
      frac_hi  <= '0;
      frac_lo  <= '0;
      tune_hz  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            lo_q  <= lo_mhz;
            err   <= 1'b0;
            state <= S_RATIO;
          end else if (reject) begin
            err  <= 1'b1;
            done <= 1'b1;
          end
        end
        S_RATIO: begin
          if (div_valid) begin
            exp_q  <= p_exp;
            vco_q  <= p_vco;
            fbhi_q <= p_fbhi;
            state  <= S_LAUNCH;
          end
        end
        S_LAUNCH: state <= S_QUOT;
        S_QUOT: begin
          if (div_valid) begin
            q_q   <= div_quot;
            state <= S_FIN;
          end
        end
        S_FIN: begin
          div_exp  <= exp_q;
          vco_mhz  <= vco_q;
          fb_presc <= f_presc;
          cp_code  <= f_pump;
          n_int    <= f_n;
          frac_hi  <= f_hi;
          frac_lo  <= f_lo;
          tune_hz  <= f_tn;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/intn_divcalc_chk.sv
`timescale 1ns/1ps
module intn_divcalc_chk
  import intn_divcalc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LO_W-1:0]   lo_mhz,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [EXP_W-1:0]  div_exp,
  input logic [LO_W-1:0]   vco_mhz,
  input logic [1:0]        fb_presc,
  input logic [LO_W-1:0]   n_int,
  input logic [HI_W-1:0]   frac_hi,
  input logic [LO_FW-1:0]  frac_lo,
  input logic              div_valid
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_div_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> busy);

  p_zero_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && lo_mhz == '0) |=> (done && err && !busy && $stable(n_int)));

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_fields_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({div_exp, vco_mhz, fb_presc, n_int, frac_hi, frac_lo}));

  p_threshold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((vco_mhz > LO_W'(VCO_SPLIT)) == (fb_presc == 2'd2)));

  p_exp_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (div_exp <= EXP_W'(EXP_CAP)));
endmodule

bind intn_divcalc intn_divcalc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .lo_mhz    (lo_mhz),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .div_exp   (div_exp),
  .vco_mhz   (vco_mhz),
  .fb_presc  (fb_presc),
  .n_int     (n_int),
  .frac_hi   (frac_hi),
  .frac_lo   (frac_lo),
  .div_valid (div_valid)
);

// File: tb/intn_divcalc_bench.sv
`timescale 1ns/1ps
module intn_divcalc_bench;
  localparam int LAT = 94;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] lo_mhz = '0;
  logic        busy, done, err;
  logic [2:0]  div_exp;
  logic [15:0] vco_mhz;
  logic [1:0]  fb_presc, cp_code;
  logic [15:0] n_int;
  logic [15:0] frac_hi;
  logic [7:0]  frac_lo;
  logic [39:0] tune_hz;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  intn_divcalc u_intn_divcalc (
    .clk(clk), .rst_n(rst_n), .start(start), .lo_mhz(lo_mhz),
    .busy(busy), .done(done), .err(err), .div_exp(div_exp),
    .vco_mhz(vco_mhz), .fb_presc(fb_presc), .cp_code(cp_code),
    .n_int(n_int), .frac_hi(frac_hi), .frac_lo(frac_lo), .tune_hz(tune_hz)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // Reference arithmetic, written directly from the requirements.
  function automatic void ref_calc(input int unsigned lo,
                                   output int unsigned e, output int unsigned vco,
                                   output int unsigned presc, output int unsigned pump,
                                   output longint unsigned nn, output longint unsigned hi,
                                   output longint unsigned lw, output longint unsigned hz);
    int unsigned x;
    int unsigned fb;
    longint unsigned q;
    x = 5400 / lo;
    e = 0;
    while (x > 1 && e < 5) begin
      e++;
      x = x / 2;
    end
    vco   = (lo * (1 << e)) % 65536;
    fb    = (vco > 3200) ? 4 : 2;
    presc = fb / 2;
    pump  = (fb == 4) ? 3 : 2;
    q     = (longint'(vco) * (64'd1 << 29)) / longint'(fb * 50);
    nn    = q / (64'd1 << 29);
    hi    = (q / (64'd1 << 13)) % 65536;
    lw    = (q / 32) % 256;
    hz    = (64'd50 * (q / 32) * fb * 64'd1000000) / ((64'd1 << e) * (64'd1 << 24));
    hz    = hz % (64'd1 << 40);
  endfunction

  // Cycle-by-cycle model state.
  int m_cnt = 0;
  bit m_done = 0, m_err = 0;
  int unsigned m_e = 0, m_vco = 0, m_presc = 0, m_pump = 0;
  longint unsigned m_n = 0, m_hi = 0, m_lo = 0, m_hz = 0;
  int unsigned p_e, p_vco, p_presc, p_pump;
  longint unsigned p_n, p_hi, p_lo, p_hz;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      fails++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_err = 0;
      m_e = 0; m_vco = 0; m_presc = 0; m_pump = 0;
      m_n = 0; m_hi = 0; m_lo = 0; m_hz = 0;
    end else begin
      m_done = 0;
      if (m_cnt != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1;
          m_e = p_e; m_vco = p_vco; m_presc = p_presc; m_pump = p_pump;
          m_n = p_n; m_hi = p_hi; m_lo = p_lo; m_hz = p_hz;
        end
      end else if (start) begin
        if (lo_mhz == 0) begin
          m_done = 1;
          m_err  = 1;
        end else begin
          m_err = 0;
          m_cnt = LAT;
          ref_calc(lo_mhz, p_e, p_vco, p_presc, p_pump, p_n, p_hi, p_lo, p_hz);
        end
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 busy", busy, (m_cnt != 0));
      chk("R7 done", done, m_done);
      chk("R8/R11 err", err, m_err);
      chk("R2 div_exp", div_exp, m_e);
      chk("R3 vco_mhz", vco_mhz, m_vco);
      chk("R4 fb_presc", fb_presc, m_presc);
      chk("R4 cp_code", cp_code, m_pump);
      chk("R5 n_int", n_int, m_n);
      chk("R5 frac_hi", frac_hi, m_hi);
      chk("R5 frac_lo", frac_lo, m_lo);
      chk("R6 tune_hz", tune_hz, m_hz);
    end
  end

  task automatic pulse(input logic [15:0] f);
    start  = 1'b1;
    lo_mhz = f;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input logic [15:0] f);
    @(negedge clk);
    pulse(f);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 n_int", n_int, 0);
    chk("R1 tune_hz", tune_hz, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(16'd2500);
    chk("R2 exp for 2500", div_exp, 1);
    chk("R3 vco for 2500", vco_mhz, 5000);
    chk("R4 presc above split", fb_presc, 2);
    chk("R4 pump above split", cp_code, 3);
    chk("R5 n for 2500", n_int, 25);
    chk("R6 tune for 2500", tune_hz, 64'd2500000000);

    run(16'd100);
    chk("R2 exp capped at 5", div_exp, 5);
    chk("R4 presc at exactly 3200", fb_presc, 1);
    chk("R4 pump at exactly 3200", cp_code, 2);
    chk("R6 tune for 100", tune_hz, 64'd100000000);

    run(16'd1601);
    chk("R4 presc at 3202", fb_presc, 2);
    chk("R5 n for 1601", n_int, 16);
    chk("R5 frac_hi for 1601", frac_hi, 655);
    chk("R5 frac_lo for 1601", frac_lo, 92);

    run(16'd5400);
    chk("R2 exp for 5400", div_exp, 0);
    chk("R5 n for 5400", n_int, 27);
    run(16'd3200);
    chk("R4 presc for 3200 direct", fb_presc, 1);
    run(16'd1);
    chk("R3 vco for 1", vco_mhz, 32);
    run(16'd6000);
    chk("R2 exp above max", div_exp, 0);
    run(16'd65535);
    chk("R3 vco for 65535", vco_mhz, 65535);

    // R8: zero request rejected, fields untouched
    run(16'd0);
    chk("R8 err on zero", err, 1);
    chk("R8 busy stays low", busy, 0);
    chk("R8 vco unchanged", vco_mhz, 65535);
    @(negedge clk);

    // R11: err cleared by next accepted request
    @(negedge clk);
    pulse(16'd2500);
    chk("R11 err cleared", err, 0);
    wait_done();

    // R9: start during busy ignored
    @(negedge clk);
    pulse(16'd2500);
    repeat (10) @(negedge clk);
    pulse(16'd7);
    wait_done();
    chk("R9 result from first request", n_int, 25);
    @(negedge clk);
    chk("R9 no second done", done, 0);

    // R10: new request in the done cycle
    run(16'd100);
    pulse(16'd1601);
    chk("R10 busy after done-cycle start", busy, 1);
    chk("R10 old result held", n_int, 32);
    wait_done();
    chk("R10 second result", n_int, 16);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule